// File: doc/BRIEF.md
# DVFS Load-Level Controller

This block holds the settings for four performance load levels and drives the clock and power logic from the level that is currently active. Each level names a CPU clock divider, a clock-source select, a PLL-bank index and a voltage select. Software fills in the level settings, writes the active level, and then turns on scaling through a dynamic-mode register. While scaling is on, the level and load registers are locked.

Each output field has its own enable bit. A master enable gates all of them. When a field is not enabled, its output stays at a safe default. The controller does not divide clocks, run PLLs, drive regulators or choose a level by itself. The active level comes only from a software write.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset, every register reads zero, `div_o` is 1, `clk_src_o`, `bank_o`, `vsel_o` and `level_o` are 0, and `level_chg_o` is low.
- R2: The level-pair registers are at offset 0x18 (levels 0 and 1) and offset 0x1C (levels 2 and 3). Each stores and reads back all 32 bits.
- R3: Within a pair register, the even level is held in bits 31:16 and the odd level in bits 15:0. Within each 16-bit half, the divider is bits 15:13, the clock-source select is bit 11, the PLL-bank index is bits 10:9 and the voltage select is bits 7:6.
- R4: The dynamic-mode register at offset 0x24 stores only these bits: 26 (clock-select enable), 28 (bank enable), 29 (divider enable), 30 (voltage enable) and 31 (master enable). All its other bits read 0.
- R5: The load register at offset 0x30 stores the active level in bits 1:0. Its other bits read 0.
- R6: While master enable bit 31 is set, writes to offsets 0x18, 0x1C and 0x30 are ignored. The dynamic-mode register can be written at any time.
- R7: While the master enable is clear, the outputs hold their defaults: divider 1, clock-source 0, bank 0 and voltage select 0.
- R8: With the master enable set, a field whose own enable bit is clear holds its default. A field whose enable bit is set follows the active level's setting.
- R9: A stored divider value of 0 drives `div_o` as 1.
- R10: The outputs and `level_o` reflect the register state one clock edge after that state changes. All outputs update on the same edge.
- R11: `level_chg_o` is high for exactly one cycle, on the same cycle that `level_o` takes a new value.
- R12: Reads of any unmapped offset return zero, and writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| div_o | output | 3 | Active CPU clock divider |
| clk_src_o | output | 1 | Clock-source select, 1 selects the PLL bank |
| bank_o | output | 2 | PLL-bank index |
| vsel_o | output | 2 | Voltage select |
| level_o | output | 2 | Applied load level |
| level_chg_o | output | 1 | One-cycle pulse when the applied level changes |

## Verification
The bench tries to rewrite the load and pair registers while the controller is locked. A design with a broken lock would change the outputs in the middle of a scaling session. The bench also clears one field enable at a time; a design that ignored those bits would pass divider or voltage settings through when they should be held at default. A stored divider of zero checks for a design that drives a divide-by-zero. Writes to the odd and even halves of each pair register check for a design that swaps the level halves. Writes of stray bits to the mode and load registers check for a design that leaks unused bits on readback.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned VSEL_W  = 2;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned HALF_W  = REG_W / 2;
  localparam int unsigned NUM_PAIR = NUM_LVL / 2;

  localparam int unsigned BIT_SRC_EN  = 26;
  localparam int unsigned BIT_BANK_EN = 28;
  localparam int unsigned BIT_DIV_EN  = 29;
  localparam int unsigned BIT_VSEL_EN = 30;
  localparam int unsigned BIT_MASTER  = 31;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic              src;
    logic [BANK_W-1:0] bank;
    logic [VSEL_W-1:0] vsel;
  } lvl_cfg_t;

  typedef struct packed {
    logic master;
    logic vsel_en;
    logic div_en;
    logic bank_en;
    logic src_en;
  } mode_t;

  function automatic lvl_cfg_t unpack_half(input logic [HALF_W-1:0] h);
    lvl_cfg_t c;
    c.div  = h[15:13];
    c.src  = h[11];
    c.bank = h[10:9];
    c.vsel = h[7:6];
    return c;
  endfunction
endpackage

// File: rtl/dvfs_regfile.sv
module dvfs_regfile
  import dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_PAIR0 = 'h18,
  parameter logic [ADDR_W-1:0] OFS_PAIR1 = 'h1C,
  parameter logic [ADDR_W-1:0] OFS_MODE  = 'h24,
  parameter logic [ADDR_W-1:0] OFS_LOAD  = 'h30
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic [NUM_PAIR-1:0][REG_W-1:0] pair_o,
  output mode_t                        mode_o,
  output logic [LVL_W-1:0]             load_o
);
  logic [NUM_PAIR-1:0][REG_W-1:0] pair_q;
  mode_t                          mode_q;
  logic [LVL_W-1:0]               load_q;
  logic                           locked;

  assign locked = mode_q.master;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q <= '0;
      mode_q <= '0;
      load_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_PAIR0 && !locked) pair_q[0] <= wdata_i;
      if (addr_i == OFS_PAIR1 && !locked) pair_q[1] <= wdata_i;
      if (addr_i == OFS_LOAD  && !locked) load_q    <= wdata_i[LVL_W-1:0];
      if (addr_i == OFS_MODE) begin
        mode_q.master  <= wdata_i[BIT_MASTER];
        mode_q.vsel_en <= wdata_i[BIT_VSEL_EN];
        mode_q.div_en  <= wdata_i[BIT_DIV_EN];
        mode_q.bank_en <= wdata_i[BIT_BANK_EN];
        mode_q.src_en  <= wdata_i[BIT_SRC_EN];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_PAIR0) rdata_o = pair_q[0];
    else if (addr_i == OFS_PAIR1) rdata_o = pair_q[1];
    else if (addr_i == OFS_LOAD) rdata_o[LVL_W-1:0] = load_q;
    else if (addr_i == OFS_MODE) begin
      rdata_o[BIT_MASTER]  = mode_q.master;
      rdata_o[BIT_VSEL_EN] = mode_q.vsel_en;
      rdata_o[BIT_DIV_EN]  = mode_q.div_en;
      rdata_o[BIT_BANK_EN] = mode_q.bank_en;
      rdata_o[BIT_SRC_EN]  = mode_q.src_en;
    end
  end

  assign pair_o = pair_q;
  assign mode_o = mode_q;
  assign load_o = load_q;

  // R6: a locked write to the load register leaves it untouched
  assert_locked_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.master && we_i && addr_i == OFS_LOAD) |=> $stable(load_q));

  // R6: a locked write to a pair register leaves it untouched
  assert_locked_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.master && we_i && (addr_i == OFS_PAIR0 || addr_i == OFS_PAIR1)) |=> $stable(pair_q));
endmodule

// File: rtl/dvfs_level_sel.sv
module dvfs_level_sel
  import dvfs_pkg::*;
(
  input  logic [NUM_PAIR-1:0][REG_W-1:0] pair_i,
  input  logic [LVL_W-1:0]               load_i,
  output lvl_cfg_t                       cfg_o
);
  lvl_cfg_t cfg [NUM_LVL];

  // even levels live in the upper half of their pair register
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    if (l % 2 == 0) begin : g_hi
      assign cfg[l] = unpack_half(pair_i[l/2][REG_W-1:HALF_W]);
    end else begin : g_lo
      assign cfg[l] = unpack_half(pair_i[l/2][HALF_W-1:0]);
    end
  end

  assign cfg_o = cfg[load_i];
endmodule

// File: rtl/dvfs_out_stage.sv
module dvfs_out_stage
  import dvfs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lvl_cfg_t          cfg_i,
  input  mode_t             mode_i,
  input  logic [LVL_W-1:0]  load_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              clk_src_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [VSEL_W-1:0] vsel_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              level_chg_o
);
  localparam logic [DIV_W-1:0] DIV_DEF = DIV_W'(1);

  logic [DIV_W-1:0]  div_d;
  logic              src_d;
  logic [BANK_W-1:0] bank_d;
  logic [VSEL_W-1:0] vsel_d;

  always_comb begin
    div_d  = DIV_DEF;
    src_d  = 1'b0;
    bank_d = '0;
    vsel_d = '0;
    if (mode_i.master) begin
      if (mode_i.div_en && cfg_i.div != '0) div_d = cfg_i.div;
      if (mode_i.src_en)  src_d  = cfg_i.src;
      if (mode_i.bank_en) bank_d = cfg_i.bank;
      if (mode_i.vsel_en) vsel_d = cfg_i.vsel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o       <= DIV_DEF;
      clk_src_o   <= 1'b0;
      bank_o      <= '0;
      vsel_o      <= '0;
      level_o     <= '0;
      level_chg_o <= 1'b0;
    end else begin
      div_o       <= div_d;
      clk_src_o   <= src_d;
      bank_o      <= bank_d;
      vsel_o      <= vsel_d;
      level_o     <= load_i;
      level_chg_o <= (load_i != level_o);
    end
  end

  // R7: a clear master enable yields defaults on the next edge
  assert_master_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i.master |=> (div_o == DIV_DEF && !clk_src_o && bank_o == '0 && vsel_o == '0));

  // R9: the divider output never reaches zero
  assert_div_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o != '0);

  // R11: the strobe marks a new applied level
  assert_strobe_change_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_chg_o |-> level_o != $past(level_o));
endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
  import dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [2:0]        div_o,
  output logic              clk_src_o,
  output logic [1:0]        bank_o,
  output logic [1:0]        vsel_o,
  output logic [1:0]        level_o,
  output logic              level_chg_o
);
  logic [NUM_PAIR-1:0][REG_W-1:0] pair;
  mode_t                          mode;
  logic [LVL_W-1:0]               load;
  lvl_cfg_t                       cfg;

  dvfs_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pair_o  (pair),
    .mode_o  (mode),
    .load_o  (load)
  );

  dvfs_level_sel u_sel (
    .pair_i (pair),
    .load_i (load),
    .cfg_o  (cfg)
  );

  dvfs_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg),
    .mode_i      (mode),
    .load_i      (load),
    .div_o       (div_o),
    .clk_src_o   (clk_src_o),
    .bank_o      (bank_o),
    .vsel_o      (vsel_o),
    .level_o     (level_o),
    .level_chg_o (level_chg_o)
  );
endmodule

// File: tb/tb_dvfs_level_ctrl.sv
module tb_dvfs_level_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  div_o;
  logic        clk_src_o;
  logic [1:0]  bank_o, vsel_o, level_o;
  logic        level_chg_o;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural model state
  logic [31:0] m_p0 = 0, m_p1 = 0, m_mode = 0;
  logic [1:0]  m_load = 0;
  logic [2:0]  e_div = 1;
  logic        e_src = 0, e_chg = 0;
  logic [1:0]  e_bank = 0, e_vsel = 0, e_lvl = 0;

  dvfs_level_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [15:0] half_of(input logic [1:0] l);
    logic [31:0] p;
    p = l[1] ? m_p1 : m_p0;
    return l[0] ? p[15:0] : p[31:16];
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h18: return m_p0;
      8'h1C: return m_p1;
      8'h24: return m_mode;
      8'h30: return {30'd0, m_load};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      logic [15:0] h;
      logic        on;
      h  = half_of(m_load);
      on = m_mode[31];
      e_div  = (on && m_mode[29] && h[15:13] != 0) ? h[15:13] : 3'd1;
      e_src  = (on && m_mode[26]) ? h[11] : 1'b0;
      e_bank = (on && m_mode[28]) ? h[10:9] : 2'd0;
      e_vsel = (on && m_mode[30]) ? h[7:6] : 2'd0;
      e_chg  = (m_load != e_lvl);
      e_lvl  = m_load;
      if (we_i) begin
        case (addr_i)
          8'h18: if (!on) m_p0 = wdata_i;
          8'h1C: if (!on) m_p1 = wdata_i;
          8'h24: m_mode = wdata_i & 32'hF400_0000;
          8'h30: if (!on) m_load = wdata_i[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2/R4/R5/R12 rdata", rdata_o, model_read(addr_i));
    chk("R3/R7/R8/R9 div", {29'd0, div_o}, {29'd0, e_div});
    chk("R3/R7/R8 clk_src", {31'd0, clk_src_o}, {31'd0, e_src});
    chk("R3/R7/R8 bank", {30'd0, bank_o}, {30'd0, e_bank});
    chk("R3/R7/R8 vsel", {30'd0, vsel_o}, {30'd0, e_vsel});
    chk("R10 level", {30'd0, level_o}, {30'd0, e_lvl});
    chk("R11 level_chg", {31'd0, level_chg_o}, {31'd0, e_chg});
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    compare_all();
    we_i = we; addr_i = a; wdata_i = d;
  endtask

  task automatic rd(input logic [7:0] a); step(1'b0, a, 32'd0); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); step(1'b1, a, d); endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state on all registers and outputs
    rd(8'h18); rd(8'h1C); rd(8'h24); rd(8'h30);
    // R2 R3: program both pair registers, stray bits included
    wr(8'h18, 32'h6DC0_0241);
    wr(8'h1C, 32'hA680_E800);
    rd(8'h18); rd(8'h1C);
    // R12: unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20); rd(8'h28);
    // R7 R10 R11: level change while disabled gives defaults
    wr(8'h30, 32'd2);
    rd(8'h30); rd(8'h30);
    // R4: enable everything; only defined bits stick
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24); rd(8'h24);
    // R6: locked writes ignored
    wr(8'h30, 32'd3);
    wr(8'h18, 32'h0000_0000);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h30); rd(8'h18); rd(8'h1C);
    // R8: drop the divider enable, then the voltage enable
    wr(8'h24, 32'hD400_0000);
    rd(8'h24); rd(8'h24);
    wr(8'h24, 32'hB400_0000);
    rd(8'h24); rd(8'h24);
    // R9: level 1 holds divider 0
    wr(8'h24, 32'h0);
    wr(8'h30, 32'd1);
    wr(8'h24, 32'hF400_0000);
    rd(8'h30); rd(8'h30);
    // R3: level 0 and level 3 when enabled
    wr(8'h24, 32'h0);
    wr(8'h30, 32'd0);
    wr(8'h24, 32'hF400_0000);
    rd(8'h18); rd(8'h18);
    wr(8'h24, 32'h0);
    // R5: stray load bits dropped
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h24, 32'hF400_0000);
    rd(8'h30); rd(8'h30); rd(8'h1C);
    rd(8'h30);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule